// File: doc/BRIEF.md
# Byte-Lane Load/Store Unit

This unit sits between a processor core's memory stage and a 32-bit, word-organised data memory with per-byte write enables. For a store it turns a byte address, an access size and the register value to be written into a word address, a write-data word with the value copied into every lane it may occupy, and a 4-bit byte-enable mask. Nothing is written back to the core on a store.

For a load it issues the word address to the memory. One cycle later, when the memory returns the word, it picks out the addressed byte or half-word and sign- or zero-extends it to 32 bits. Byte order is little-endian: offset 0 within a word is bits 7:0 and offset 3 is bits 31:24. An access whose size does not fit its alignment is flagged, and it reaches the memory neither as a read nor as a write.

Top module: `lsu_lane_unit`

## Requirements
- R1: While reset (rst_n low, sampled at the clock edge) has been applied and no load has been issued since, load_valid is 0; with req_valid low, mem_req is 0 and mem_wen is 4'b0000.
- R2: A byte store (req_size 2'b00) with offset k = req_addr[1:0] drives mem_wen = 4'b0001 << k and mem_wdata = four copies of req_wdata[7:0].
- R3: A half-word store (req_size 2'b01) at even offset k drives mem_wen = 4'b0011 << k and mem_wdata = two copies of req_wdata[15:0].
- R4: A word store (req_size 2'b10) at offset 0 drives mem_wen = 4'b1111 and mem_wdata = req_wdata; for every accepted access, mem_addr = req_addr[31:2] and mem_req is 1 in the request cycle.
- R5: A half-word at an odd offset, a word at a nonzero offset, or the reserved size 2'b11 raises misalign_err in the request cycle, holds mem_req low and mem_wen at 4'b0000, and is followed by no load_valid.
- R6: A signed byte load (req_unsigned 0) returns byte k of the memory word (bits 8k+7:8k) in bits 7:0, with that byte's bit 7 copied into bits 31:8.
- R7: An unsigned byte load (req_unsigned 1) returns byte k in bits 7:0 and zeros in bits 31:8.
- R8: A half-word load takes bits 15:0 of the word when req_addr[1] is 0 and bits 31:16 when it is 1, then extends from bit 15 with copies of it (signed) or with zeros (unsigned).
- R9: A word load returns the memory word unchanged, whatever req_unsigned is.
- R10: load_valid is 1 exactly in the cycle after an accepted load request, with load_data valid in that cycle; a store request is never followed by load_valid.
- R11: After the word 0xFFFFF8F5 is stored at word address A, a signed byte load from A+1 returns 0xFFFFFFF8 and an unsigned one returns 0x000000F8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 half-word, 10 word, 11 reserved |
| req_unsigned | input | 1 | Load extension: 1 = zero, 0 = sign |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store value, right-aligned |
| mem_req | output | 1 | Memory access strobe |
| mem_addr | output | 30 | Word address |
| mem_wen | output | 4 | Per-byte write enables |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_rdata | input | 32 | Word read, one cycle after mem_req |
| misalign_err | output | 1 | Request refused for alignment or size |
| load_valid | output | 1 | load_data holds a result |
| load_data | output | 32 | Extended load result |

## Verification
The bench sweeps every size, offset and signedness over a small memory filled with bytes on both sides of 0x80, so a unit that takes the wrong lane, or that reverses the byte order, returns a neighbouring byte. A unit that extends from the wrong bit, or that zero-fills a signed load, fails on the bytes that have bit 7 set. Stores of each size land in a scratch word that is then read back, which shows whether the enables and the lane copies agree. Refused sizes and offsets must leave that word untouched and give no load result, which catches a unit that flags the error but still writes.

// File: rtl/lsu_pkg.sv
// Shared definitions for the load/store lane unit.
// Assumes a 32-bit data path split into 8-bit lanes.
package lsu_pkg;
    localparam int XLEN   = 32;
    localparam int NBYTES = XLEN / 8;
    localparam int OFF_W  = $clog2(NBYTES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_t;
endpackage

// File: rtl/lsu_store_align.sv
// Request decode: alignment check, byte enables and lane-replicated data.
// Purely combinational; assumes one request per cycle from the core.
module lsu_store_align
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              valid,
    input  logic              write,
    input  acc_size_t         size,
    input  logic [ADDR_W-1:0] addr,
    input  logic [XLEN-1:0]   wdata,
    output logic              err,
    output logic              accept,
    output logic [NBYTES-1:0] wen,
    output logic [XLEN-1:0]   lane_data,
    output logic [ADDR_W-OFF_W-1:0] word_addr
);
    logic [OFF_W-1:0]  off;
    logic              bad;
    logic [NBYTES-1:0] be;

    assign off       = addr[OFF_W-1:0];
    assign word_addr = addr[ADDR_W-1:OFF_W];

    // Alignment rule per size; the reserved code is always refused.
    always_comb begin
        case (size)
            SZ_BYTE: bad = 1'b0;
            SZ_HALF: bad = off[0];
            SZ_WORD: bad = (off != '0);
            default: bad = 1'b1;
        endcase
    end

    // Per-lane enable and data selection.
    for (genvar i = 0; i < NBYTES; i++) begin : g_lane
        localparam logic [OFF_W-1:0] LANE = OFF_W'(i);
        always_comb begin
            case (size)
                SZ_BYTE: begin
                    be[i]             = (off == LANE);
                    lane_data[8*i +: 8] = wdata[7:0];
                end
                SZ_HALF: begin
                    be[i]             = (off[OFF_W-1] == LANE[OFF_W-1]);
                    lane_data[8*i +: 8] = wdata[8*(i%2) +: 8];
                end
                SZ_WORD: begin
                    be[i]             = 1'b1;
                    lane_data[8*i +: 8] = wdata[8*i +: 8];
                end
                default: begin
                    be[i]             = 1'b0;
                    lane_data[8*i +: 8] = wdata[8*i +: 8];
                end
            endcase
        end
    end

    assign err    = valid & bad;
    assign accept = valid & ~bad;
    assign wen    = be & {NBYTES{valid & write & ~bad}};
endmodule

// File: rtl/lsu_load_extract.sv
// Load return path: remembers the offset, size and signedness of an
// accepted load, then selects and extends the word the memory returns
// one cycle later. Assumes a memory with a one-cycle read latency.
module lsu_load_extract
    import lsu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [OFF_W-1:0] off,
    input  acc_size_t        size,
    input  logic             zext,
    input  logic [XLEN-1:0]  rdata,
    output logic             load_valid,
    output logic [XLEN-1:0]  load_data
);
    logic             vld_q;
    logic [OFF_W-1:0] off_q;
    acc_size_t        size_q;
    logic             zext_q;
    logic [7:0]       sel_b;
    logic [15:0]      sel_h;

    // Hold the load context until the data returns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            off_q  <= '0;
            size_q <= SZ_WORD;
            zext_q <= 1'b0;
        end else begin
            vld_q <= capture;
            if (capture) begin
                off_q  <= off;
                size_q <= size;
                zext_q <= zext;
            end
        end
    end

    // Lane selection, little-endian.
    always_comb begin
        sel_b = rdata[8*off_q +: 8];
        sel_h = off_q[OFF_W-1] ? rdata[31:16] : rdata[15:0];
    end

    // Extension to full width.
    always_comb begin
        case (size_q)
            SZ_BYTE: load_data = {{(XLEN-8){sel_b[7] & ~zext_q}}, sel_b};
            SZ_HALF: load_data = {{(XLEN-16){sel_h[15] & ~zext_q}}, sel_h};
            default: load_data = rdata;
        endcase
    end

    assign load_valid = vld_q;

    a_r6_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && size_q == SZ_BYTE && !zext_q) |-> (load_data[XLEN-1:8] == {(XLEN-8){load_data[7]}}));
    a_r7_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && size_q == SZ_BYTE && zext_q) |-> (load_data[XLEN-1:8] == '0));
    a_r8_half_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && size_q == SZ_HALF && zext_q) |-> (load_data[XLEN-1:16] == '0));
endmodule

// File: rtl/lsu_lane_unit.sv
// Top of the load/store lane unit. Requests are decoded in the cycle they
// arrive; load results appear one cycle later. Assumes the memory samples
// mem_req/mem_addr/mem_wen at the clock edge and returns read data after it.
module lsu_lane_unit
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic              req_unsigned,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [XLEN-1:0]   req_wdata,
    output logic              mem_req,
    output logic [ADDR_W-OFF_W-1:0] mem_addr,
    output logic [NBYTES-1:0] mem_wen,
    output logic [XLEN-1:0]   mem_wdata,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic              misalign_err,
    output logic              load_valid,
    output logic [XLEN-1:0]   load_data
);
    acc_size_t size_e;
    logic      accept;

    assign size_e = acc_size_t'(req_size);

    lsu_store_align #(.ADDR_W(ADDR_W)) u_align (
        .valid     (req_valid),
        .write     (req_write),
        .size      (size_e),
        .addr      (req_addr),
        .wdata     (req_wdata),
        .err       (misalign_err),
        .accept    (accept),
        .wen       (mem_wen),
        .lane_data (mem_wdata),
        .word_addr (mem_addr)
    );

    assign mem_req = accept;

    lsu_load_extract u_load (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (accept & ~req_write),
        .off        (req_addr[OFF_W-1:0]),
        .size       (size_e),
        .zext       (req_unsigned),
        .rdata      (mem_rdata),
        .load_valid (load_valid),
        .load_data  (load_data)
    );

    a_r5_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_err |-> (mem_wen == '0 && !mem_req));
    a_r5_no_result: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_err |=> !load_valid);
    a_r10_store_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> !load_valid);
    a_r2_lane_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wen != '0) |-> ($countones(mem_wen) == 1 || mem_wen == 4'b0011 ||
                             mem_wen == 4'b1100 || mem_wen == 4'b1111));
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!mem_req && mem_wen == '0));
endmodule

// File: tb/tb_lsu_lane_unit.sv
`timescale 1ns/1ps
module tb_lsu_lane_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_unsigned = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        mem_req, misalign_err, load_valid;
    logic [29:0] mem_addr;
    logic [3:0]  mem_wen;
    logic [31:0] mem_wdata, load_data;
    logic [31:0] mem_rdata = '0;
    logic [31:0] mem [16];
    logic [31:0] shadow [16];
    int tests = 0, fails = 0;

    always #2.5 clk = ~clk;

    lsu_lane_unit dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_unsigned(req_unsigned), .req_addr(req_addr),
        .req_wdata(req_wdata), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_wen(mem_wen), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .misalign_err(misalign_err), .load_valid(load_valid), .load_data(load_data)
    );

    // Word memory with byte enables and one-cycle read.
    always @(posedge clk) begin
        if (mem_req) begin
            mem_rdata <= mem[mem_addr[3:0]];
            for (int b = 0; b < 4; b++)
                if (mem_wen[b]) mem[mem_addr[3:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
        end
    end

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_load(input logic [31:0] w, input int sz, input bit u, input int off);
        logic [7:0]  b;
        logic [15:0] h;
        b = w[8*off +: 8];
        h = w[16*(off/2) +: 16];
        if (sz == 0) return u ? {24'h0, b} : {{24{b[7]}}, b};
        if (sz == 1) return u ? {16'h0, h} : {{16{h[15]}}, h};
        return w;
    endfunction

    // One request; checks the request-cycle outputs, then the next cycle.
    task automatic access(input bit wr, input int sz, input bit u, input logic [31:0] a,
                          input logic [31:0] d, input string rq);
        int  off = int'(a[1:0]);
        bit  bad = (sz == 3) || (sz == 1 && off[0]) || (sz == 2 && off != 0);
        logic [3:0]  ewen;
        logic [31:0] edat, eload;
        ewen = (sz == 0) ? (4'b0001 << off) : (sz == 1) ? (4'b0011 << off) : 4'b1111;
        edat = (sz == 0) ? {4{d[7:0]}} : (sz == 1) ? {2{d[15:0]}} : d;
        eload = exp_load(shadow[a[5:2]], sz, u, off);
        req_valid = 1'b1; req_write = wr; req_size = 2'(sz); req_unsigned = u;
        req_addr = a; req_wdata = d;
        #1;
        check({rq, " R5 err"}, {31'h0, misalign_err}, {31'h0, bad});
        check({rq, " R4 req"}, {31'h0, mem_req}, {31'h0, !bad});
        if (!bad) check({rq, " R4 addr"}, {2'b0, mem_addr}, {2'b0, a[31:2]});
        if (wr && !bad) begin
            check({rq, " R2 R3 R4 wen"}, {28'h0, mem_wen}, {28'h0, ewen});
            check({rq, " R2 R3 R4 wdata"}, mem_wdata, edat);
            for (int b = 0; b < 4; b++)
                if (ewen[b]) shadow[a[5:2]][8*b +: 8] = edat[8*b +: 8];
        end else begin
            check({rq, " R5 wen off"}, {28'h0, mem_wen}, 32'h0);
        end
        @(negedge clk);
        req_valid = 1'b0;
        #0.5;
        check({rq, " R10 valid"}, {31'h0, load_valid}, {31'h0, (!wr && !bad)});
        if (!wr && !bad) check(rq, load_data, eload);
    endtask

    initial begin
        #(5.0 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int w = 0; w < 16; w++) begin mem[w] = '0; shadow[w] = '0; end
        repeat (3) @(negedge clk);
        check("R1 load_valid", {31'h0, load_valid}, 32'h0);
        check("R1 mem_req", {31'h0, mem_req}, 32'h0);
        check("R1 mem_wen", {28'h0, mem_wen}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R4: fill with bytes on both sides of 0x80.
        for (int w = 0; w < 15; w++)
            access(1, 2, 0, 32'(w * 4),
                   {8'(8'h81 + w * 7), 8'(8'h3C + w * 5), 8'(8'hF0 ^ w), 8'(8'h0E + w * 9)}, "R4 fill");
        // R2 R3 R5: every size and offset into scratch word 15, read back as a word.
        for (int sz = 0; sz < 4; sz++)
            for (int off = 0; off < 4; off++) begin
                access(1, sz, 0, 32'(60 + off), 32'hA1B2C3D4 ^ 32'(sz * 16 + off), "R2 R3 store");
                access(0, 2, 0, 32'd60, 32'h0, "R9 scratch readback");
            end
        // R6 R7 R8 R9 R5: full load sweep.
        for (int w = 0; w < 16; w++)
            for (int off = 0; off < 4; off++)
                for (int sz = 0; sz < 4; sz++)
                    for (int u = 0; u < 2; u++)
                        access(0, sz, u[0], 32'(w * 4 + off), 32'h0,
                               sz == 0 ? (u == 1 ? "R7 lbu" : "R6 lb") :
                               sz == 1 ? "R8 half" : "R9 word");
        // R11: fixed example.
        access(1, 2, 0, 32'h20, 32'hFFFFF8F5, "R11 store");
        access(0, 0, 0, 32'h21, 32'h0, "R11 lb");
        check("R11 lb value", load_data, 32'hFFFFFFF8);
        access(0, 0, 1, 32'h21, 32'h0, "R11 lbu");
        check("R11 lbu value", load_data, 32'h000000F8);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule